// File: doc/BRIEF.md
# Clock-Synchronous Serial Transceiver

This block moves 8-bit frames over a three-wire synchronous link: one data output, one data input and a transfer clock. There are no start or stop bits; every frame is exactly eight clock pulses. The block can be the clock master, dividing the system clock to make the transfer clock, or the slave, shifting on a clock applied from outside. Software reaches it through a small register bus: a data register (writes fill the transmit buffer, reads drain the receive buffer), a control register and a divider register.

The control register picks the clock polarity, the bit order, inversion of the data logic, continuous receive mode, the clock source, and which of two clock pins carries the master clock. In continuous receive mode, reading the received byte re-arms the transmitter with the byte already held in the transmit buffer. A master can therefore stream in frames with no further writes. Three flags report the buffer state: transmit buffer empty, receive complete and overrun.

Control register bits: [0] polarity, [1] MSB-first, [2] invert, [3] continuous receive, [4] external clock, [5] two-pin clock steering, [6] pin select. Register addresses: 0 data, 1 control, 2 divider.

Top module: `csio_top`

## Requirements
- R1: After reset, tx_empty is 1, rx_full and overrun are 0, sdo is 1, pin A drives (sck_a_oe=1) at the idle level 1, and pin B is not driven (sck_b_oe=0).
- R2: As master, each frame produces exactly 8 transfer-clock pulses. Every half period lasts divider+1 system clocks. The line then returns to its idle level.
- R3: With polarity 0 the clock idles high, sdo changes on the falling edge, and sdi is sampled on the rising edge.
- R4: With polarity 1 the clock idles low, sdo changes on the rising edge, and sdi is sampled on the falling edge.
- R5: With MSB-first 0, bit 0 of the word goes first on both sdo and sdi. With MSB-first 1, bit 7 goes first.
- R6: With invert 1, every transmitted bit is the complement of the written bit, and reading data returns the complement of the received bits.
- R7: rx_full is set on the 8th sampling edge and cleared by a read of register 0. That read returns the received byte.
- R8: If a frame completes while rx_full is still 1, overrun becomes 1. A read of register 0 clears it.
- R9: With continuous receive 1, a read of register 0 sets the transmit buffer full (tx_empty=0) with no write. A new frame then transmits the held byte.
- R10: With steering 1 and internal clock, pin select 0 drives pin A and pin select 1 drives pin B. The other pin has its enable at 0 and its output at the idle level.
- R11: With external clock 1, both clock enables are 0 and the frame shifts on edges arriving at sck_a_in, using the same edge roles as R3.
- R12: A write to register 0 clears tx_empty. tx_empty returns to 1 once the frame starts shifting that byte.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst | input | 1 | Synchronous active-high reset |
| bus_wr | input | 1 | Register write strobe |
| bus_rd | input | 1 | Register read strobe |
| bus_addr | input | 2 | Register address |
| bus_wdata | input | 8 | Write data |
| bus_rdata | output | 8 | Read data |
| sdi | input | 1 | Serial data in |
| sdo | output | 1 | Serial data out |
| sck_a_in | input | 1 | Clock input on pin A (slave mode) |
| sck_a_out | output | 1 | Clock output on pin A |
| sck_a_oe | output | 1 | Drive enable of pin A |
| sck_b_out | output | 1 | Clock output on pin B |
| sck_b_oe | output | 1 | Drive enable of pin B |
| tx_empty | output | 1 | Transmit buffer empty |
| rx_full | output | 1 | Receive complete |
| overrun | output | 1 | Frame lost to an unread buffer |

## Verification
The hardest state to reach is the re-armed frame in continuous receive mode. It needs a finished frame, an unread buffer, the mode bit set, and then a read with no write in between. The bench gets there by completing a normal frame and then reading register 0. It checks that the transmit buffer turns full at once and that the next frame carries the earlier byte. The mode is turned off again before the final read, so that read does not start a third frame. Overrun is reached the same way, by completing two frames back to back without a read. The bench plays the far end of the link itself. It watches the chosen clock pin, drives sdi on leading edges and samples sdo on trailing edges, so the checks hold for any clock timing.

// File: rtl/csio_pkg.sv
package csio_pkg;

    // Control register layout, bit 0 = pol
    typedef struct packed {
        logic pin_sel;
        logic multi_pin;
        logic ext_clk;
        logic cont_rx;
        logic invert;
        logic msb_first;
        logic pol;
    } csio_cfg_t;

    localparam int CFG_W = $bits(csio_cfg_t);

    typedef enum logic [1:0] {
        REG_DATA = 2'd0,
        REG_CTRL = 2'd1,
        REG_DIV  = 2'd2,
        REG_NONE = 2'd3
    } csio_reg_e;

    typedef struct packed {
        logic lead;   // edge leaving idle level: drive
        logic trail;  // edge returning to idle: sample
    } csio_edge_t;

    function automatic logic idle_of(input logic pol);
        return ~pol;
    endfunction

endpackage

// File: rtl/csio_regs.sv
module csio_regs
    import csio_pkg::*;
#(
    parameter int DATA_W   = 8,
    parameter int DIV_W    = 8,
    parameter int DIV_INIT = 3
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              wr_en,
    input  logic              rd_en,
    input  logic [1:0]        addr,
    input  logic [DATA_W-1:0] wdata,
    output logic [DATA_W-1:0] rdata,
    output csio_cfg_t         cfg,
    output logic [DIV_W-1:0]  div,
    output logic [DATA_W-1:0] tx_word,
    output logic              tx_full,
    input  logic              take,
    input  logic              done,
    input  logic [DATA_W-1:0] rx_word,
    output logic              rx_full,
    output logic              overrun
);

    logic [DATA_W-1:0] ctrl_q;
    logic [DATA_W-1:0] txbuf_q;
    logic [DATA_W-1:0] rxbuf_q;
    logic [DATA_W-1:0] inv_mask;
    logic              wr_data, wr_ctrl, wr_div, rd_data;

    assign cfg      = csio_cfg_t'(ctrl_q[CFG_W-1:0]);
    assign inv_mask = {DATA_W{cfg.invert}};
    assign tx_word  = txbuf_q ^ inv_mask;

    assign wr_data = wr_en && (csio_reg_e'(addr) == REG_DATA);
    assign wr_ctrl = wr_en && (csio_reg_e'(addr) == REG_CTRL);
    assign wr_div  = wr_en && (csio_reg_e'(addr) == REG_DIV);
    assign rd_data = rd_en && (csio_reg_e'(addr) == REG_DATA);

    always_comb begin
        unique case (csio_reg_e'(addr))
            REG_DATA: rdata = rxbuf_q ^ inv_mask;
            REG_CTRL: rdata = ctrl_q;
            REG_DIV:  rdata = DATA_W'(div);
            default:  rdata = '0;
        endcase
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            ctrl_q  <= '0;
            div     <= DIV_W'(DIV_INIT);
            txbuf_q <= '0;
            tx_full <= 1'b0;
            rxbuf_q <= '0;
            rx_full <= 1'b0;
            overrun <= 1'b0;
        end else begin
            if (wr_ctrl) ctrl_q <= wdata;
            if (wr_div)  div    <= DIV_W'(wdata);
            if (wr_data) txbuf_q <= wdata;

            if (wr_data || (rd_data && cfg.cont_rx))
                tx_full <= 1'b1;
            else if (take)
                tx_full <= 1'b0;

            if (done) begin
                rxbuf_q <= rx_word;
                rx_full <= 1'b1;
                if (rx_full) overrun <= 1'b1;
            end else if (rd_data) begin
                rx_full <= 1'b0;
                overrun <= 1'b0;
            end
        end
    end

    // R7: completion flag only rises after a finished frame
    a_r7_full_from_done: assert property (@(posedge clk) disable iff (rst)
        $rose(rx_full) |-> $past(done));

    // R8: overrun needs an unread buffer
    a_r8_overrun_needs_full: assert property (@(posedge clk) disable iff (rst)
        $rose(overrun) |-> $past(rx_full));

    // R9: read in continuous mode re-arms the transmitter
    a_r9_cont_rearm: assert property (@(posedge clk) disable iff (rst)
        (rd_data && cfg.cont_rx) |=> tx_full);

    // R12: shifter only takes a filled buffer
    a_r12_take_full: assert property (@(posedge clk) disable iff (rst)
        take |-> tx_full);

endmodule

// File: rtl/csio_clkgen.sv
module csio_clkgen
    import csio_pkg::*;
#(
    parameter int DIV_W       = 8,
    parameter int SYNC_STAGES = 2
) (
    input  logic             clk,
    input  logic             rst,
    input  logic             run,
    input  logic             pol,
    input  logic             ext_clk,
    input  logic [DIV_W-1:0] div,
    input  logic             sck_in,
    output logic             sck_int,
    output csio_edge_t       edges
);

    logic [DIV_W-1:0]       cnt;
    logic                   phase;
    logic [SYNC_STAGES-1:0] sync_q;
    logic                   ext_prev;
    logic                   ext_lvl;
    logic                   idle;
    logic                   tick;
    logic                   ext_change;

    assign idle       = idle_of(pol);
    assign ext_lvl    = sync_q[SYNC_STAGES-1];
    assign tick       = run && !ext_clk && (cnt == div);
    assign ext_change = run && ext_clk && (ext_lvl != ext_prev);
    assign sck_int    = idle ^ phase;

    always_comb begin
        if (ext_clk) begin
            edges.lead  = ext_change && (ext_lvl != idle);
            edges.trail = ext_change && (ext_lvl == idle);
        end else begin
            edges.lead  = tick && !phase;
            edges.trail = tick && phase;
        end
    end

    always_ff @(posedge clk) begin
        if (rst || !run || ext_clk) begin
            cnt   <= '0;
            phase <= 1'b0;
        end else if (cnt == div) begin
            cnt   <= '0;
            phase <= ~phase;
        end else begin
            cnt <= cnt + 1'b1;
        end
    end

    always_ff @(posedge clk) begin
        if (rst) begin
            sync_q   <= '1;
            ext_prev <= 1'b1;
        end else begin
            sync_q   <= {sync_q[SYNC_STAGES-2:0], sck_in};
            ext_prev <= ext_lvl;
        end
    end

    // R2: the internal half-period counter never passes the divider
    a_r2_cnt_bound: assert property (@(posedge clk) disable iff (rst)
        (run && !ext_clk && $stable(div)) |-> (cnt <= div));

endmodule

// File: rtl/csio_shifter.sv
module csio_shifter
    import csio_pkg::*;
#(
    parameter int DATA_W = 8
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              msb_first,
    input  logic              tx_full,
    input  logic [DATA_W-1:0] tx_word,
    input  csio_edge_t        edges,
    input  logic              sdi,
    output logic              busy,
    output logic              take,
    output logic              done,
    output logic [DATA_W-1:0] rx_word,
    output logic              sdo
);

    localparam int CNT_W = $clog2(DATA_W);
    localparam logic [CNT_W-1:0] LAST = CNT_W'(DATA_W - 1);

    logic [CNT_W-1:0]  cnt;
    logic [DATA_W-1:0] txsh;
    logic [DATA_W-1:0] rxsh;
    logic [DATA_W-1:0] rx_next;

    assign take    = !busy && tx_full;
    assign rx_next = msb_first ? {rxsh[DATA_W-2:0], sdi} : {sdi, rxsh[DATA_W-1:1]};
    assign done    = busy && edges.trail && (cnt == LAST);
    assign rx_word = rx_next;

    always_ff @(posedge clk) begin
        if (rst) begin
            busy <= 1'b0;
            cnt  <= '0;
            txsh <= '0;
            rxsh <= '0;
            sdo  <= 1'b1;
        end else if (take) begin
            busy <= 1'b1;
            cnt  <= '0;
            txsh <= tx_word;
        end else if (busy) begin
            if (edges.lead) begin
                sdo  <= msb_first ? txsh[DATA_W-1] : txsh[0];
                txsh <= msb_first ? (txsh << 1) : (txsh >> 1);
            end
            if (edges.trail) begin
                rxsh <= rx_next;
                if (cnt == LAST) busy <= 1'b0;
                else             cnt  <= cnt + 1'b1;
            end
        end
    end

    // R2: a clock event is either a drive or a sample, never both
    a_r2_edge_excl: assert property (@(posedge clk) disable iff (rst)
        !(edges.lead && edges.trail));

    // R7: a frame ends only while shifting
    a_r7_done_busy: assert property (@(posedge clk) disable iff (rst)
        done |=> !busy);

endmodule

// File: rtl/csio_top.sv
module csio_top
    import csio_pkg::*;
#(
    parameter int DATA_W      = 8,
    parameter int DIV_W       = 8,
    parameter int DIV_INIT    = 3,
    parameter int SYNC_STAGES = 2
) (
    input  logic              clk,
    input  logic              rst,
    input  logic              bus_wr,
    input  logic              bus_rd,
    input  logic [1:0]        bus_addr,
    input  logic [DATA_W-1:0] bus_wdata,
    output logic [DATA_W-1:0] bus_rdata,
    input  logic              sdi,
    output logic              sdo,
    input  logic              sck_a_in,
    output logic              sck_a_out,
    output logic              sck_a_oe,
    output logic              sck_b_out,
    output logic              sck_b_oe,
    output logic              tx_empty,
    output logic              rx_full,
    output logic              overrun
);

    localparam int PINS = 2;

    csio_cfg_t         cfg;
    logic [DIV_W-1:0]  div;
    logic [DATA_W-1:0] tx_word, rx_word;
    logic              tx_full, take, done, busy;
    logic              sck_int, idle, drive_sel;
    csio_edge_t        edges;
    logic [PINS-1:0]   pin_out, pin_oe;

    csio_regs #(.DATA_W(DATA_W), .DIV_W(DIV_W), .DIV_INIT(DIV_INIT)) u_regs (
        .clk(clk), .rst(rst), .wr_en(bus_wr), .rd_en(bus_rd), .addr(bus_addr),
        .wdata(bus_wdata), .rdata(bus_rdata), .cfg(cfg), .div(div),
        .tx_word(tx_word), .tx_full(tx_full), .take(take), .done(done),
        .rx_word(rx_word), .rx_full(rx_full), .overrun(overrun)
    );

    csio_clkgen #(.DIV_W(DIV_W), .SYNC_STAGES(SYNC_STAGES)) u_clk (
        .clk(clk), .rst(rst), .run(busy), .pol(cfg.pol), .ext_clk(cfg.ext_clk),
        .div(div), .sck_in(sck_a_in), .sck_int(sck_int), .edges(edges)
    );

    csio_shifter #(.DATA_W(DATA_W)) u_shift (
        .clk(clk), .rst(rst), .msb_first(cfg.msb_first), .tx_full(tx_full),
        .tx_word(tx_word), .edges(edges), .sdi(sdi), .busy(busy), .take(take),
        .done(done), .rx_word(rx_word), .sdo(sdo)
    );

    assign tx_empty  = !tx_full;
    assign idle      = idle_of(cfg.pol);
    assign drive_sel = cfg.multi_pin ? cfg.pin_sel : 1'b0;

    for (genvar p = 0; p < PINS; p++) begin : g_pin
        assign pin_oe[p]  = !cfg.ext_clk && (drive_sel == 1'(p));
        assign pin_out[p] = pin_oe[p] ? sck_int : idle;
    end

    assign sck_a_out = pin_out[0];
    assign sck_a_oe  = pin_oe[0];
    assign sck_b_out = pin_out[1];
    assign sck_b_oe  = pin_oe[1];

    // R10: at most one clock pin driven
    a_r10_one_pin: assert property (@(posedge clk) disable iff (rst)
        $onehot0({sck_a_oe, sck_b_oe}));

    // R11: external clock leaves both pins undriven
    a_r11_ext_quiet: assert property (@(posedge clk) disable iff (rst)
        cfg.ext_clk |-> !(sck_a_oe || sck_b_oe));

    // R3: clock rests at idle whenever the shifter is stopped
    a_r3_idle_stopped: assert property (@(posedge clk) disable iff (rst)
        !busy |-> (sck_int == idle));

endmodule

// File: tb/tb_csio_top.sv
module tb_csio_top;

    logic       clk = 1'b0;
    logic       rst = 1'b1;
    logic       bus_wr = 1'b0, bus_rd = 1'b0;
    logic [1:0] bus_addr = '0;
    logic [7:0] bus_wdata = '0;
    logic [7:0] bus_rdata;
    logic       sdi = 1'b0, sdo;
    logic       sck_a_in = 1'b1;
    logic       sck_a_out, sck_a_oe, sck_b_out, sck_b_oe;
    logic       tx_empty, rx_full, overrun;

    int n_chk = 0, n_fail = 0;
    logic pol_now = 1'b0;

    always #10 clk = ~clk;

    csio_top dut (
        .clk(clk), .rst(rst), .bus_wr(bus_wr), .bus_rd(bus_rd), .bus_addr(bus_addr),
        .bus_wdata(bus_wdata), .bus_rdata(bus_rdata), .sdi(sdi), .sdo(sdo),
        .sck_a_in(sck_a_in), .sck_a_out(sck_a_out), .sck_a_oe(sck_a_oe),
        .sck_b_out(sck_b_out), .sck_b_oe(sck_b_oe), .tx_empty(tx_empty),
        .rx_full(rx_full), .overrun(overrun)
    );

    task automatic chk(input string req, input int act, input int exp);
        n_chk++;
        if (act != exp) begin
            n_fail++;
            $display("FAIL %s: actual 0x%0h expected 0x%0h", req, act, exp);
        end
    endtask

    task automatic bus_write(input logic [1:0] a, input logic [7:0] d);
        @(negedge clk);
        bus_wr = 1'b1; bus_addr = a; bus_wdata = d;
        @(posedge clk);
        @(negedge clk);
        bus_wr = 1'b0;
    endtask

    task automatic bus_read(input logic [1:0] a, output logic [7:0] d);
        @(negedge clk);
        bus_rd = 1'b1; bus_addr = a;
        #1 d = bus_rdata;
        @(posedge clk);
        @(negedge clk);
        bus_rd = 1'b0;
    endtask

    task automatic set_cfg(input logic pol, input logic msb, input logic inv,
                           input logic cont, input logic ext, input logic multi,
                           input logic sel, input logic [7:0] dv);
        pol_now = pol;
        sck_a_in = ~pol;
        bus_write(2'd2, dv);
        bus_write(2'd1, {1'b0, sel, multi, ext, cont, inv, msb, pol});
    endtask

    // Plays the far end of a master frame on the selected pin
    task automatic watch_frame(input logic on_b, input logic msb, input logic [7:0] drive,
                               output logic [7:0] got, output int pulses,
                               output int hmin, output int hmax, output int stray);
        logic prev, cur, oprev, ocur, idle, first;
        int bits, since;
        idle = ~pol_now;
        got = '0; pulses = 0; hmin = 1000; hmax = 0; stray = 0;
        bits = 0; since = 0; first = 1'b1;
        prev  = on_b ? sck_b_out : sck_a_out;
        oprev = on_b ? sck_a_out : sck_b_out;
        for (int g = 0; g < 3000; g++) begin
            @(negedge clk);
            cur  = on_b ? sck_b_out : sck_a_out;
            ocur = on_b ? sck_a_out : sck_b_out;
            since++;
            if (ocur != oprev) stray++;
            if (cur != prev) begin
                if (!first) begin
                    if (since < hmin) hmin = since;
                    if (since > hmax) hmax = since;
                end
                first = 1'b0;
                since = 0;
                if (cur != idle) begin
                    pulses++;
                    if (bits < 8) sdi = msb ? drive[7-bits] : drive[bits];
                end else if (bits < 8) begin
                    if (msb) got[7-bits] = sdo; else got[bits] = sdo;
                    bits++;
                end
            end
            prev = cur; oprev = ocur;
            if (bits == 8 && since > 40) break;
        end
    endtask

    task automatic slave_frame(input logic msb, input logic [7:0] drive, output logic [7:0] got,
                               output int drove);
        logic idle;
        idle = ~pol_now;
        got = '0; drove = 0;
        for (int b = 0; b < 8; b++) begin
            @(negedge clk);
            sdi = msb ? drive[7-b] : drive[b];
            sck_a_in = ~idle;
            repeat (8) begin @(negedge clk); if (sck_a_oe || sck_b_oe) drove++; end
            if (msb) got[7-b] = sdo; else got[b] = sdo;
            sck_a_in = idle;
            repeat (8) @(negedge clk);
        end
        repeat (4) @(negedge clk);
    endtask

    task automatic t_reset;
        @(negedge clk);
        chk("R1 tx_empty", tx_empty, 1);
        chk("R1 rx_full", rx_full, 0);
        chk("R1 overrun", overrun, 0);
        chk("R1 sdo", sdo, 1);
        chk("R1 sck_a_out", sck_a_out, 1);
        chk("R1 sck_a_oe", sck_a_oe, 1);
        chk("R1 sck_b_oe", sck_b_oe, 0);
    endtask

    task automatic t_basic;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 8'd2);
        bus_write(2'd0, 8'hA5);
        chk("R12 tx_empty after write", tx_empty, 0);
        watch_frame(0, 0, 8'h3C, got, p, hmn, hmx, st);
        chk("R3 R5 lsb sdo word", got, 8'hA5);
        chk("R2 pulse count", p, 8);
        chk("R2 half period min", hmn, 3);
        chk("R2 half period max", hmx, 3);
        chk("R2 idle after frame", sck_a_out, 1);
        chk("R12 tx_empty after start", tx_empty, 1);
        chk("R7 rx_full set", rx_full, 1);
        bus_read(2'd0, rd);
        chk("R7 R3 received word", rd, 8'h3C);
        chk("R7 rx_full cleared", rx_full, 0);
    endtask

    task automatic t_msb_pol1;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(1, 1, 0, 0, 0, 0, 0, 8'd1);
        @(negedge clk);
        chk("R4 idle low", sck_a_out, 0);
        bus_write(2'd0, 8'h96);
        watch_frame(0, 1, 8'h4D, got, p, hmn, hmx, st);
        chk("R4 R5 msb sdo word", got, 8'h96);
        chk("R4 pulse count", p, 8);
        chk("R2 R4 half period", hmx, 2);
        bus_read(2'd0, rd);
        chk("R4 R5 msb received", rd, 8'h4D);
    endtask

    task automatic t_invert;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(0, 0, 1, 0, 0, 0, 0, 8'd1);
        bus_write(2'd0, 8'h3C);
        watch_frame(0, 0, 8'h81, got, p, hmn, hmx, st);
        chk("R6 inverted sdo", got, 8'hC3);
        bus_read(2'd0, rd);
        chk("R6 inverted read", rd, 8'h7E);
    endtask

    task automatic t_overrun;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(0, 0, 0, 0, 0, 0, 0, 8'd1);
        bus_write(2'd0, 8'h11);
        watch_frame(0, 0, 8'h22, got, p, hmn, hmx, st);
        chk("R8 no overrun first", overrun, 0);
        bus_write(2'd0, 8'h33);
        watch_frame(0, 0, 8'h44, got, p, hmn, hmx, st);
        chk("R8 overrun set", overrun, 1);
        bus_read(2'd0, rd);
        chk("R8 newest word kept", rd, 8'h44);
        chk("R8 overrun cleared", overrun, 0);
    endtask

    task automatic t_cont;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(0, 0, 0, 1, 0, 0, 0, 8'd1);
        bus_write(2'd0, 8'h5A);
        watch_frame(0, 0, 8'h01, got, p, hmn, hmx, st);
        chk("R9 first frame sdo", got, 8'h5A);
        bus_read(2'd0, rd);
        chk("R9 first read", rd, 8'h01);
        chk("R9 rearmed tx_empty", tx_empty, 0);
        watch_frame(0, 0, 8'h02, got, p, hmn, hmx, st);
        chk("R9 filler resent", got, 8'h5A);
        chk("R9 second frame pulses", p, 8);
        set_cfg(0, 0, 0, 0, 0, 0, 0, 8'd1);
        bus_read(2'd0, rd);
        chk("R9 second read", rd, 8'h02);
        repeat (20) @(negedge clk);
        chk("R9 no frame after mode off", tx_empty, 1);
    endtask

    task automatic t_pin_b;
        logic [7:0] got, rd; int p, hmn, hmx, st;
        set_cfg(0, 0, 0, 0, 0, 1, 1, 8'd1);
        @(negedge clk);
        chk("R10 pin B enabled", sck_b_oe, 1);
        chk("R10 pin A released", sck_a_oe, 0);
        bus_write(2'd0, 8'hE7);
        watch_frame(1, 0, 8'h18, got, p, hmn, hmx, st);
        chk("R10 word on pin B clock", got, 8'hE7);
        chk("R10 pin B pulses", p, 8);
        chk("R10 pin A held idle", st, 0);
        bus_read(2'd0, rd);
        chk("R10 received via pin B", rd, 8'h18);
        set_cfg(0, 0, 0, 0, 0, 1, 0, 8'd1);
        @(negedge clk);
        chk("R10 select 0 pin A", sck_a_oe, 1);
        chk("R10 select 0 pin B off", sck_b_oe, 0);
    endtask

    task automatic t_slave;
        logic [7:0] got, rd; int drove;
        set_cfg(0, 0, 0, 0, 1, 0, 0, 8'd1);
        repeat (4) @(negedge clk);
        chk("R11 pin A undriven", sck_a_oe, 0);
        chk("R11 pin B undriven", sck_b_oe, 0);
        bus_write(2'd0, 8'hC6);
        slave_frame(0, 8'h35, got, drove);
        chk("R11 slave sdo word", got, 8'hC6);
        chk("R11 no drive during frame", drove, 0);
        chk("R11 rx_full", rx_full, 1);
        bus_read(2'd0, rd);
        chk("R11 slave received", rd, 8'h35);
    endtask

    initial begin
        repeat (150000) @(posedge clk);
        n_fail++;
        $display("FAIL watchdog: actual timeout expected completion");
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

    initial begin
        repeat (3) @(negedge clk);
        rst = 1'b0;
        t_reset();
        t_basic();
        t_msb_pol1();
        t_invert();
        t_overrun();
        t_cont();
        t_pin_b();
        t_slave();
        $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
        $finish;
    end

endmodule